// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block detects read-after-write hazards in a four-stage pipeline (fetch, register read, ALU, write-back) that has no forwarding paths. Every cycle it looks at the instruction sitting in the register-read stage and asks whether any register it is about to read is still owed by an older instruction in the ALU or write-back stage. A result reaches the register file only at the end of the write-back cycle. Any such pending producer therefore means the read would return a stale value.

When a hazard exists, the unit raises a stall that freezes the fetch and register-read stages. In the same cycle it raises a NOP-select that makes the ALU-stage instruction register load the no-op ADD(r31, r31, r31) in place of the held instruction. The no-op writes r31, so it never causes a hazard of its own. The stall clears by itself once the producer has left write-back. A consumer directly behind its producer therefore sees two bubbles, one with a single instruction between them sees one, and one further away sees none. The decision is purely combinational on the stage fields, so both outputs answer in the same cycle as their inputs.

Top module: `interlock_unit`

## Requirements
- R1: With no pending producer for any register read by the register-read stage instruction, `stall` and `nop_sel` are both 0. This includes the state in which every stage holds the no-op (opcode 0x20, all register fields 31).
- R2: The bench packs instructions as opcode in bits 31:26, destination rc in bits 25:21, ra in bits 20:16 and rb in bits 15:11, and drives the field ports from those slices.
- R3: An opcode whose two top bits are 2'b10 (register-register operation) reads ra and rb and writes rc.
- R4: An opcode whose two top bits are 2'b11 (constant operation) reads ra and writes rc. Its rb field never raises a hazard.
- R5: Opcode 0x18 (load), 0x1B (jump) and 0x1C/0x1D (branches) read ra and write rc. Opcode 0x19 (store) reads ra and rc and writes nothing. Opcode 0x1F (relative load) reads nothing and writes rc. Every other opcode reads and writes nothing.
- R6: A writing instruction in the ALU stage whose destination equals a register read by the register-read stage instruction raises `stall` in that cycle.
- R7: A writing instruction in the write-back stage whose destination equals a register read by the register-read stage instruction raises `stall` in that cycle.
- R8: A producer whose destination is r31 never causes a stall.
- R9: `nop_sel` equals `stall` in every cycle.
- R10: In a pipeline that holds the two early stages and injects no-ops on `stall`, a consumer that directly follows its producer is delayed 2 cycles. With one instruction between them it is delayed 1 cycle, and with two or more it is not delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, used by the embedded checks |
| rf_op | input | 6 | Opcode of the register-read stage instruction |
| rf_ra | input | 5 | ra field of the register-read stage instruction |
| rf_rb | input | 5 | rb field of the register-read stage instruction |
| rf_rc | input | 5 | rc field of the register-read stage instruction |
| alu_op | input | 6 | Opcode of the ALU stage instruction |
| alu_rc | input | 5 | Destination field of the ALU stage instruction |
| wb_op | input | 6 | Opcode of the write-back stage instruction |
| wb_rc | input | 5 | Destination field of the write-back stage instruction |
| stall | output | 1 | Hold fetch and register-read stages this cycle |
| nop_sel | output | 1 | Load the no-op into the ALU-stage instruction register |

## Verification
The bench targets the opcode classes whose operand use differs. A constant operation carries a stale rb value; a design that decoded rb for it would stall for no reason. A store needs its rc treated as a source; a design that missed this would let a store write stale data. A store sitting in the ALU stage must not count as a producer, or it would cause phantom stalls. An r31 destination, which every injected no-op carries, must be harmless, or the pipeline would deadlock on its own bubbles. A pipelined run at producer distances of one, two and three instructions checks the bubble counts of two, one and zero; a design that forgot the write-back comparison would give only one bubble for an adjacent consumer.

// File: rtl/interlock_unit.sv
module interlock_unit #(
  parameter int OPW = 6,
  parameter int RW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] rf_op,
  input  logic [RW-1:0]  rf_ra,
  input  logic [RW-1:0]  rf_rb,
  input  logic [RW-1:0]  rf_rc,
  input  logic [OPW-1:0] alu_op,
  input  logic [RW-1:0]  alu_rc,
  input  logic [OPW-1:0] wb_op,
  input  logic [RW-1:0]  wb_rc,
  output logic           stall,
  output logic           nop_sel
);

  localparam logic [RW-1:0]  ZERO_REG = {RW{1'b1}};
  localparam logic [OPW-1:0] OP_LD  = OPW'(6'h18);
  localparam logic [OPW-1:0] OP_ST  = OPW'(6'h19);
  localparam logic [OPW-1:0] OP_JMP = OPW'(6'h1B);
  localparam logic [OPW-1:0] OP_BEQ = OPW'(6'h1C);
  localparam logic [OPW-1:0] OP_BNE = OPW'(6'h1D);
  localparam logic [OPW-1:0] OP_LDR = OPW'(6'h1F);

  // {writes rc, reads ra, reads rb, reads rc}
  function automatic logic [3:0] decode(input logic [OPW-1:0] op);
    logic [3:0] d;
    case (op[OPW-1:OPW-2])
      2'b10: d = 4'b1110;
      2'b11: d = 4'b1100;
      default: begin
        if (op == OP_LD || op == OP_JMP || op == OP_BEQ || op == OP_BNE) d = 4'b1100;
        else if (op == OP_ST)  d = 4'b0101;
        else if (op == OP_LDR) d = 4'b1000;
        else                   d = 4'b0000;
      end
    endcase
    return d;
  endfunction

  logic [3:0] rf_d, alu_d, wb_d;
  assign rf_d  = decode(rf_op);
  assign alu_d = decode(alu_op);
  assign wb_d  = decode(wb_op);

  logic alu_wr, wb_wr;
  assign alu_wr = alu_d[3] && (alu_rc != ZERO_REG);
  assign wb_wr  = wb_d[3]  && (wb_rc  != ZERO_REG);

  logic hit_alu, hit_wb;
  assign hit_alu = alu_wr && ((rf_d[2] && rf_ra == alu_rc) ||
                              (rf_d[1] && rf_rb == alu_rc) ||
                              (rf_d[0] && rf_rc == alu_rc));
  assign hit_wb  = wb_wr  && ((rf_d[2] && rf_ra == wb_rc) ||
                              (rf_d[1] && rf_rb == wb_rc) ||
                              (rf_d[0] && rf_rc == wb_rc));

  assign stall   = hit_alu || hit_wb;
  assign nop_sel = stall;

  // R8
  r31_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_rc == ZERO_REG && wb_rc == ZERO_REG) |-> !stall);

  // R4
  const_rb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_op[OPW-1:OPW-2] == 2'b11 && rf_ra != alu_rc && rf_ra != wb_rc) |-> !stall);

  // R5
  no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_d[3] && !wb_d[3]) |-> !nop_sel);

  // R6
  alu_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_d[3] && alu_rc != ZERO_REG && rf_d[2] && rf_ra == alu_rc) |-> stall);

  // R7
  wb_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_d[3] && wb_rc != ZERO_REG && rf_d[1] && rf_rb == wb_rc) |-> nop_sel);

endmodule

// File: tb/sim_interlock_unit.sv
module sim_interlock_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] w_rf, w_alu, w_wb;
  logic stall, nop_sel;
  int checks = 0, fails = 0;

  localparam logic [31:0] NOP = 32'h83FF_F800;

  interlock_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .rf_op(w_rf[31:26]), .rf_ra(w_rf[20:16]), .rf_rb(w_rf[15:11]), .rf_rc(w_rf[25:21]),
    .alu_op(w_alu[31:26]), .alu_rc(w_alu[25:21]),
    .wb_op(w_wb[31:26]), .wb_rc(w_wb[25:21]),
    .stall(stall), .nop_sel(nop_sel)
  );

  // R2: field packing
  function automatic logic [31:0] mk(input int op, input int rc, input int ra, input int rb);
    return {op[5:0], rc[4:0], ra[4:0], rb[4:0], 11'b0};
  endfunction

  function automatic bit writes(input logic [31:0] w);
    int op = int'(w[31:26]);
    if (op >= 32) return 1;
    return op == 24 || op == 27 || op == 28 || op == 29 || op == 31;
  endfunction

  function automatic bit ref_stall(input logic [31:0] rf, input logic [31:0] alu, input logic [31:0] wb);
    int op = int'(rf[31:26]);
    int srcs[$];
    logic [31:0] prod[2];
    if (op >= 32) srcs.push_back(int'(rf[20:16]));
    if (op >= 32 && op < 48) srcs.push_back(int'(rf[15:11]));
    if (op == 24 || op == 25 || op == 27 || op == 28 || op == 29) srcs.push_back(int'(rf[20:16]));
    if (op == 25) srcs.push_back(int'(rf[25:21]));
    prod[0] = alu; prod[1] = wb;
    foreach (prod[k])
      if (writes(prod[k]) && prod[k][25:21] != 5'd31)
        foreach (srcs[j]) if (srcs[j] == int'(prod[k][25:21])) return 1;
    return 0;
  endfunction

  task automatic cmp(input bit exp, input string tag);
    checks++;
    if (stall !== exp) begin
      fails++;
      $display("FAIL %s stall actual=%b expected=%b", tag, stall, exp);
    end
    checks++;
    if (nop_sel !== exp) begin
      fails++;
      $display("FAIL R9 %s nop_sel actual=%b expected=%b", tag, nop_sel, exp);
    end
  endtask

  task automatic vec(input logic [31:0] rf, input logic [31:0] alu, input logic [31:0] wb,
                     input bit exp, input string tag);
    @(posedge clk); #1;
    w_rf = rf; w_alu = alu; w_wb = wb;
    @(negedge clk);
    cmp(exp, tag);
  endtask

  task automatic run_gap(input int gap);
    logic [31:0] prog[$];
    logic [31:0] p_rf = NOP, p_alu = NOP, p_wb = NOP;
    int bubbles = 0, tail = 0, expb;
    bit e;
    prog.push_back(mk(32, 3, 1, 2));
    for (int i = 0; i < gap; i++) prog.push_back(mk(32, 7, 1, 2));
    prog.push_back(mk(33, 5, 3, 2));
    for (int i = 0; i < 4; i++) prog.push_back(mk(48, 9, 1, 0));
    while (tail < 4) begin
      @(posedge clk); #1;
      w_rf = p_rf; w_alu = p_alu; w_wb = p_wb;
      @(negedge clk);
      e = ref_stall(p_rf, p_alu, p_wb);
      cmp(e, "R10 pipeline");
      if (e) bubbles++;
      p_wb = p_alu;
      if (e) p_alu = NOP;
      else begin
        p_alu = p_rf;
        if (prog.size() > 0) p_rf = prog.pop_front();
        else begin p_rf = NOP; tail++; end
      end
    end
    expb = (gap >= 2) ? 0 : 2 - gap;
    checks++;
    if (bubbles != expb) begin
      fails++;
      $display("FAIL R10 gap=%0d bubbles actual=%0d expected=%0d", gap, bubbles, expb);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    w_rf = NOP; w_alu = NOP; w_wb = NOP;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    vec(NOP, NOP, NOP, 0, "R1 reset state");
    vec(mk(33, 5, 3, 2), mk(32, 3, 1, 2), NOP, 1, "R3 R6 ra from ALU");
    vec(mk(33, 5, 2, 3), mk(32, 3, 1, 2), NOP, 1, "R3 rb from ALU");
    vec(mk(33, 5, 3, 2), NOP, mk(32, 3, 1, 2), 1, "R7 ra from WB");
    vec(mk(33, 5, 4, 2), mk(32, 3, 1, 2), mk(32, 6, 1, 2), 0, "R1 no match");
    vec(mk(48, 5, 1, 3), mk(32, 3, 1, 2), mk(32, 3, 1, 2), 0, "R4 const rb ignored");
    vec(mk(48, 5, 3, 0), mk(32, 3, 1, 2), NOP, 1, "R4 const ra");
    vec(mk(25, 3, 1, 0), mk(32, 3, 4, 2), NOP, 1, "R5 store rc source");
    vec(mk(33, 5, 3, 2), mk(25, 3, 1, 0), NOP, 0, "R5 store not producer");
    vec(mk(31, 5, 3, 3), mk(32, 3, 1, 2), NOP, 0, "R5 ldr reads none");
    vec(mk(33, 5, 3, 2), mk(31, 3, 0, 0), NOP, 1, "R5 ldr producer");
    vec(mk(24, 5, 3, 0), NOP, mk(27, 3, 1, 0), 1, "R5 load after jump");
    vec(mk(28, 5, 3, 0), mk(29, 3, 1, 0), NOP, 1, "R5 branch pair");
    vec(mk(0, 3, 3, 3), mk(32, 3, 1, 2), NOP, 0, "R5 illegal consumer");
    vec(mk(33, 5, 3, 2), mk(0, 3, 1, 2), mk(1, 3, 0, 0), 0, "R5 illegal producer");
    vec(mk(33, 5, 31, 31), mk(32, 31, 1, 2), mk(48, 31, 1, 0), 0, "R8 r31 dest");
    run_gap(0);
    run_gap(1);
    run_gap(2);
    run_gap(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule